// File: doc/BRIEF.md
# Command Issue and Auto-Stop Sequencer

This block sits between a register interface and the card-side command port of a memory-card host. Software writes a 32-bit command word and a 32-bit argument. Setting the launch bit in the command word starts a sequence. The sequencer presents the command index and argument on a valid/ready request port, waits for the card-side response, and stores short or long responses into four response words. It then emits one-cycle pulses on an interrupt-status set vector. Commands that only change the card clock complete at once, without any card transaction.

When the command asks for an automatic stop and the data path reports that no transfer bytes remain, the sequencer issues stop command index 12 with a zero argument. It does this after the user command completes, or when the data path reports a 32-bit data-port access while the sequencer is idle. The software-visible command and argument registers are never overwritten by the injected stop command. Serial encoding, CRC, clock division and the data path itself belong to neighbouring blocks.

Top module: `sdcmd_sequencer`

## Requirements
- R1: After synchronous reset, `busy`, `card_req_valid` and `status_set` are 0, and `cmd_word`, `cmd_arg` and `resp_words` are all zero.
- R2: A write with `reg_wr_sel`=0 stores the command word with bit 31 forced to 0. The command launches only if bit 31 of the written data was 1. A write with `reg_wr_sel`=1 stores the argument.
- R3: While a command is issued, `card_req_index` carries command bits [5:0] and `card_req_arg` carries the argument register. `card_req_valid` and both request fields hold steady until `card_req_ready` is seen high.
- R4: A launched command with bit 21 set raises no card request. `status_set` bit 2 pulses for one cycle, two cycles after the launching write.
- R5: Bit 6 requests a response and bit 7 selects the long form. Response byte k arrives in `card_rsp_data[127-8k -: 8]`. For an accepted short response, word 0 (`resp_words[31:0]`) takes bytes 0..3 as a big-endian value (`card_rsp_data[127:96]`), and words 1 to 3 become 0. Status bit 2 then pulses.
- R6: For an accepted long response, word 0 takes the last four bytes (`card_rsp_data[31:0]`) and word 3 (`resp_words[127:96]`) takes the first four (`card_rsp_data[127:96]`). Words 1 and 2 follow the same reversed order.
- R7: `card_rsp_len` is coded 0 = none, 1 = 4 bytes, 2 = 16 bytes. An error flag, or a length code that does not match the requested form, pulses status bit 1 instead of bit 2 and leaves `resp_words` unchanged. A command without bit 6 completes on any error-free length and leaves `resp_words` unchanged.
- R8: If bit 12 is set and `xfer_zero` is high when the user command completes, a stop command follows with index 12 and argument 0, using the user command's bits 6, 7 and 21. Its completion pulses bit 14 together with its own bit 2 or bit 1. `cmd_word` and `cmd_arg` are unchanged by this.
- R9: While idle, a `data_access` pulse with bit 12 of `cmd_word` set and `xfer_zero` high starts the same stop sequence. Without `xfer_zero`, the pulse starts nothing.
- R10: While `busy` is high, register writes and `data_access` pulses are ignored. A command with bit 12 set issues no stop if `xfer_zero` is low at completion.
- R11: `busy` rises in the cycle after a launch and stays high through the final status pulse. It falls one cycle later, and no pulse appears while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects command word, 1 selects argument |
| reg_wr_data | input | 32 | Register write data |
| data_access | input | 1 | One-cycle pulse per 32-bit data-port access |
| xfer_zero | input | 1 | Remaining transfer count is zero |
| card_req_valid | output | 1 | Command request valid |
| card_req_ready | input | 1 | Card side accepts request |
| card_req_index | output | 6 | Command index of request |
| card_req_arg | output | 32 | Command argument of request |
| card_rsp_valid | input | 1 | Response present for one cycle |
| card_rsp_err | input | 1 | Card reported an error |
| card_rsp_len | input | 2 | Response length code |
| card_rsp_data | input | 128 | Response bytes, first byte in the top bits |
| cmd_word | output | 32 | Stored command word |
| cmd_arg | output | 32 | Stored argument |
| resp_words | output | 128 | Four response words, word i at bits [32i+31:32i] |
| busy | output | 1 | Sequence in progress |
| status_set | output | 32 | One-cycle set pulses: bit 1 no response, bit 2 done, bit 14 auto-stop done |

## Verification
The bench sweeps every pairing of response-expected and long-form bits against every length code and the error flag. A design that ignored the length check would report completion and overwrite the response words where it must report no-response. Long responses use four distinct words, so a design that kept the received order instead of reversing it shows swapped words. The auto-stop cases check that the stop request carries index 12 and a zero argument while the visible command and argument survive unchanged. A design that stored the stop in the user registers, or triggered it without a zero transfer count, is exposed there. Writes, launches and data-port pulses sent while busy must leave the stored registers and the sequence untouched.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int WORD_W       = 32;
    localparam int IDX_W        = 6;
    localparam int STAT_W       = 32;

    // command word bit positions
    localparam int BIT_LAUNCH   = 31;
    localparam int BIT_CLKCHG   = 21;
    localparam int BIT_AUTOSTOP = 12;
    localparam int BIT_RSPLONG  = 7;
    localparam int BIT_RSPEXP   = 6;

    // interrupt-status set positions decoded by the status register
    localparam int ST_NORSP     = 1;
    localparam int ST_DONE      = 2;
    localparam int ST_AUTO      = 14;

    typedef enum logic [1:0] {
        LEN_NONE  = 2'd0,
        LEN_SHORT = 2'd1,
        LEN_LONG  = 2'd2
    } rsp_len_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_REQ,
        SQ_RSP,
        SQ_FIN
    } sq_state_e;

    typedef struct packed {
        logic             clkchg;
        logic             autostop;
        logic             rsp_long;
        logic             rsp_exp;
        logic [IDX_W-1:0] index;
    } cmd_flags_t;

    function automatic cmd_flags_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_flags_t f;
        f.clkchg   = w[BIT_CLKCHG];
        f.autostop = w[BIT_AUTOSTOP];
        f.rsp_long = w[BIT_RSPLONG];
        f.rsp_exp  = w[BIT_RSPEXP];
        f.index    = w[IDX_W-1:0];
        return f;
    endfunction

    function automatic logic rsp_ok(input cmd_flags_t f, input logic err,
                                    input logic [1:0] len);
        if (err)
            return 1'b0;
        else if (!f.rsp_exp)
            return 1'b1;
        else if (f.rsp_long)
            return len == LEN_LONG;
        else
            return len == LEN_SHORT;
    endfunction

endpackage

// File: rtl/sdcmd_cmdregs.sv
module sdcmd_cmdregs
    import sdcmd_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         busy,
    output logic [W-1:0] cmd_q,
    output logic [W-1:0] arg_q,
    output logic         launch
);

    localparam logic [W-1:0] LAUNCH_MASK = ~(W'(1) << BIT_LAUNCH);

    logic wr_ok;

    assign wr_ok  = wr_en && !busy;
    assign launch = wr_ok && !wr_sel && wr_data[BIT_LAUNCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            arg_q <= '0;
        end else if (wr_ok) begin
            if (!wr_sel)
                cmd_q <= wr_data & LAUNCH_MASK;
            else
                arg_q <= wr_data;
        end
    end

    // R10: a write arriving while busy changes neither register
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        busy && wr_en |=> $stable(cmd_q) && $stable(arg_q));

endmodule

// File: rtl/sdcmd_rsp_capture.sv
module sdcmd_rsp_capture
    import sdcmd_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int WORDS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic               cap_long,
    input  logic [WORDS*W-1:0] rsp_data,
    output logic [WORDS*W-1:0] resp_q
);

    localparam int TOT_W = WORDS * W;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [W-1:0] nxt;
        // long form: word i comes from received bytes in reversed word order
        // short form: only word 0, taken from the first received bytes
        if (i == 0) begin : g_first
            assign nxt = cap_long ? rsp_data[W-1:0] : rsp_data[TOT_W-1 -: W];
        end else begin : g_rest
            assign nxt = cap_long ? rsp_data[i*W +: W] : '0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                resp_q[i*W +: W] <= '0;
            else if (cap_en)
                resp_q[i*W +: W] <= nxt;
        end
    end

    // R5: a short capture leaves the upper words cleared
    p_short_clear_r5: assert property (@(posedge clk) disable iff (rst)
        cap_en && !cap_long |=> resp_q[TOT_W-1:W] == '0);

endmodule

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm
    import sdcmd_pkg::*;
#(
    parameter int W          = WORD_W,
    parameter int STOP_INDEX = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  cmd_flags_t        flags,
    input  logic [W-1:0]      arg_q,
    input  logic              data_access,
    input  logic              xfer_zero,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [IDX_W-1:0]  req_index,
    output logic [W-1:0]      req_arg,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [1:0]        rsp_len,
    output logic              busy,
    output logic [STAT_W-1:0] status_set,
    output logic              cap_en
);

    localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(STOP_INDEX);

    sq_state_e state;
    logic      stop_q;
    logic      ok_q;
    logic      want_stop;

    assign want_stop = flags.autostop && xfer_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            stop_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (launch) begin
                        stop_q <= 1'b0;
                        state  <= SQ_START;
                    end else if (data_access && want_stop) begin
                        stop_q <= 1'b1;
                        state  <= SQ_START;
                    end
                end
                SQ_START: begin
                    if (flags.clkchg) begin
                        ok_q  <= 1'b1;
                        state <= SQ_FIN;
                    end else begin
                        state <= SQ_REQ;
                    end
                end
                SQ_REQ: begin
                    if (req_ready)
                        state <= SQ_RSP;
                end
                SQ_RSP: begin
                    if (rsp_valid) begin
                        ok_q  <= rsp_ok(flags, rsp_err, rsp_len);
                        state <= SQ_FIN;
                    end
                end
                SQ_FIN: begin
                    if (!stop_q && want_stop) begin
                        stop_q <= 1'b1;
                        state  <= SQ_START;
                    end else begin
                        state  <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = state != SQ_IDLE;
    assign req_valid = state == SQ_REQ;
    assign req_index = stop_q ? STOP_IDX : flags.index;
    assign req_arg   = stop_q ? '0 : arg_q;
    assign cap_en    = (state == SQ_RSP) && rsp_valid && flags.rsp_exp
                       && rsp_ok(flags, rsp_err, rsp_len);

    always_comb begin
        status_set = '0;
        if (state == SQ_FIN) begin
            status_set[ST_DONE]  = ok_q;
            status_set[ST_NORSP] = !ok_q;
            status_set[ST_AUTO]  = stop_q;
        end
    end

    // R3: request and its fields are held until accepted
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_index) && $stable(req_arg));

    // R7: a no-response pulse always follows a card response
    p_norsp_after_card_r7: assert property (@(posedge clk) disable iff (rst)
        status_set[ST_NORSP] |-> $past(rsp_valid));

    // R11: nothing is requested or pulsed while idle
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> status_set == '0 && !req_valid);

endmodule

// File: rtl/sdcmd_sequencer.sv
module sdcmd_sequencer
    import sdcmd_pkg::*;
#(
    parameter int STOP_INDEX = 12,
    parameter int RSP_WORDS  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr_en,
    input  logic                        reg_wr_sel,
    input  logic [WORD_W-1:0]           reg_wr_data,
    input  logic                        data_access,
    input  logic                        xfer_zero,
    output logic                        card_req_valid,
    input  logic                        card_req_ready,
    output logic [IDX_W-1:0]            card_req_index,
    output logic [WORD_W-1:0]           card_req_arg,
    input  logic                        card_rsp_valid,
    input  logic                        card_rsp_err,
    input  logic [1:0]                  card_rsp_len,
    input  logic [RSP_WORDS*WORD_W-1:0] card_rsp_data,
    output logic [WORD_W-1:0]           cmd_word,
    output logic [WORD_W-1:0]           cmd_arg,
    output logic [RSP_WORDS*WORD_W-1:0] resp_words,
    output logic                        busy,
    output logic [STAT_W-1:0]           status_set
);

    logic       launch;
    logic       cap_en;
    cmd_flags_t flags;

    assign flags = decode_cmd(cmd_word);

    sdcmd_cmdregs #(.W(WORD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .busy    (busy),
        .cmd_q   (cmd_word),
        .arg_q   (cmd_arg),
        .launch  (launch)
    );

    sdcmd_fsm #(.W(WORD_W), .STOP_INDEX(STOP_INDEX)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .flags       (flags),
        .arg_q       (cmd_arg),
        .data_access (data_access),
        .xfer_zero   (xfer_zero),
        .req_valid   (card_req_valid),
        .req_ready   (card_req_ready),
        .req_index   (card_req_index),
        .req_arg     (card_req_arg),
        .rsp_valid   (card_rsp_valid),
        .rsp_err     (card_rsp_err),
        .rsp_len     (card_rsp_len),
        .busy        (busy),
        .status_set  (status_set),
        .cap_en      (cap_en)
    );

    sdcmd_rsp_capture #(.W(WORD_W), .WORDS(RSP_WORDS)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_long (flags.rsp_long),
        .rsp_data (card_rsp_data),
        .resp_q   (resp_words)
    );

    // R4: clock-change commands never reach the card port
    p_clkchg_nobus_r4: assert property (@(posedge clk) disable iff (rst)
        card_req_valid |-> !cmd_word[BIT_CLKCHG]);

endmodule

// File: tb/test_sdcmd_sequencer.sv
module test_sdcmd_sequencer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic         reg_wr_sel = 1'b0;
    logic [31:0]  reg_wr_data = '0;
    logic         data_access = 1'b0;
    logic         xfer_zero = 1'b0;
    logic         card_req_valid;
    logic         card_req_ready = 1'b0;
    logic [5:0]   card_req_index;
    logic [31:0]  card_req_arg;
    logic         card_rsp_valid = 1'b0;
    logic         card_rsp_err = 1'b0;
    logic [1:0]   card_rsp_len = '0;
    logic [127:0] card_rsp_data = '0;
    logic [31:0]  cmd_word;
    logic [31:0]  cmd_arg;
    logic [127:0] resp_words;
    logic         busy;
    logic [31:0]  status_set;

    int n_checks = 0;
    int n_fail   = 0;
    logic [127:0] model_resp = '0;

    localparam logic [31:0] S_NORSP = 32'h0000_0002;
    localparam logic [31:0] S_DONE  = 32'h0000_0004;
    localparam logic [31:0] S_AUTO  = 32'h0000_4000;

    always #2 clk = ~clk;

    sdcmd_sequencer i_sdcmd_sequencer (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .data_access(data_access), .xfer_zero(xfer_zero),
        .card_req_valid(card_req_valid), .card_req_ready(card_req_ready),
        .card_req_index(card_req_index), .card_req_arg(card_req_arg),
        .card_rsp_valid(card_rsp_valid), .card_rsp_err(card_rsp_err),
        .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
        .cmd_word(cmd_word), .cmd_arg(cmd_arg), .resp_words(resp_words),
        .busy(busy), .status_set(status_set)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    // entered at a negedge where a request should be pending; leaves at the
    // negedge where the completion pulse is visible
    task automatic serve(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                         input int dly, input logic err, input logic [1:0] len,
                         input logic [127:0] data);
        chk({tag, " R3 req_valid"}, 128'(card_req_valid), 128'd1);
        chk({tag, " R3 index"}, 128'(card_req_index), 128'(idx));
        chk({tag, " R3 arg"}, 128'(card_req_arg), 128'(arg));
        for (int k = 0; k < dly; k++) begin
            tick();
            chk({tag, " R3 held"}, {95'd0, card_req_valid, card_req_arg}, {95'd1, arg});
        end
        card_req_ready = 1'b1;
        tick();
        card_req_ready = 1'b0;
        chk({tag, " R3 dropped"}, 128'(card_req_valid), 128'd0);
        card_rsp_valid = 1'b1; card_rsp_err = err; card_rsp_len = len; card_rsp_data = data;
        tick();
        card_rsp_valid = 1'b0;
    endtask

    function automatic logic [127:0] mkdata(input int t);
        logic [127:0] d;
        for (int j = 0; j < 4; j++)
            d[j*32 +: 32] = {8'(t), 8'(j), 8'h5A, 8'(t ^ j)};
        return d;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] w;
        logic [127:0] d;
        logic ok;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 busy/valid", {126'd0, busy, card_req_valid}, 128'd0);
        chk("R1 status", 128'(status_set), 128'd0);
        chk("R1 regs", {64'd0, cmd_word, cmd_arg}, 128'd0);
        chk("R1 resp", resp_words, 128'd0);

        // R2 store without launch
        wr(1'b0, 32'h0000_0045);
        chk("R2 no launch busy", 128'(busy), 128'd0);
        chk("R2 stored", 128'(cmd_word), 128'h45);
        tick();
        chk("R2 no request", 128'(card_req_valid), 128'd0);

        // R5 R6 R7 sweep over response type, length code and error
        for (int ti = 0; ti < 4; ti++) begin
            for (int ln = 0; ln < 4; ln++) begin
                for (int er = 0; er < 2; er++) begin
                    int t;
                    t = ti * 8 + ln * 2 + er;
                    w = 32'h8000_0000 | 32'(t + 1);
                    w[6] = ti[0];
                    w[7] = ti[1];
                    d = mkdata(t);
                    wr(1'b1, 32'hC0DE_0000 + 32'(t));
                    wr(1'b0, w);
                    chk("R2 launch bit cleared", 128'(cmd_word), 128'(w & 32'h7FFF_FFFF));
                    chk("R11 busy after launch", {126'd0, busy, card_req_valid}, 128'd2);
                    tick();
                    serve("sweep", 6'(t + 1), 32'hC0DE_0000 + 32'(t), (ln + er) % 3,
                          er[0], ln[1:0], d);
                    ok = !er[0] && (!ti[0] || (ti[1] ? (ln == 2) : (ln == 1)));
                    if (ok && ti[0])
                        model_resp = ti[1] ? d : {96'd0, d[127:96]};
                    chk(ok ? "R5/R6 done pulse" : "R7 norsp pulse", 128'(status_set),
                        128'(ok ? S_DONE : S_NORSP));
                    chk(ti[1] ? "R6 long words" : "R5 short words", resp_words, model_resp);
                    chk("R11 busy at pulse", 128'(busy), 128'd1);
                    tick();
                    chk("R11 idle after", {95'd0, busy, status_set}, 128'd0);
                end
            end
        end

        // R4 clock change: no bus, done pulse two cycles after write
        wr(1'b0, 32'h8020_0011);
        chk("R4 first cycle", {95'd0, card_req_valid, status_set}, 128'd0);
        tick();
        chk("R4 done pulse", {95'd0, card_req_valid, status_set}, 128'(S_DONE));
        chk("R4 resp untouched", resp_words, model_resp);
        tick();
        chk("R4 idle", 128'(busy), 128'd0);

        // R4 R8 clock change with auto-stop also skips the bus
        xfer_zero = 1'b1;
        wr(1'b0, 32'h8020_1011);
        tick();
        chk("R4 clk+stop user done", 128'(status_set), 128'(S_DONE));
        tick();
        chk("R8 clk stop start", {95'd0, card_req_valid, status_set}, 128'd0);
        tick();
        chk("R8 clk stop done", {95'd0, card_req_valid, status_set}, 128'(S_DONE | S_AUTO));
        tick();
        chk("R8 clk stop idle", 128'(busy), 128'd0);

        // R8 auto-stop after launch, short response for both commands
        wr(1'b1, 32'hDEAD_0001);
        wr(1'b0, 32'h8000_1053);
        tick();
        d = mkdata(40);
        serve("R8 user", 6'h13, 32'hDEAD_0001, 1, 1'b0, 2'd1, d);
        chk("R8 user done", 128'(status_set), 128'(S_DONE));
        chk("R8 user resp", resp_words, {96'd0, d[127:96]});
        tick();
        tick();
        d = mkdata(41);
        serve("R8 stop", 6'd12, 32'd0, 0, 1'b0, 2'd1, d);
        chk("R8 stop pulse", 128'(status_set), 128'(S_DONE | S_AUTO));
        chk("R8 stop resp", resp_words, {96'd0, d[127:96]});
        chk("R8 regs restored", {64'd0, cmd_word, cmd_arg}, {64'd0, 32'h0000_1053, 32'hDEAD_0001});
        tick();
        chk("R8 idle", 128'(busy), 128'd0);
        model_resp = resp_words;

        // R9 stop from data access, card reports error
        data_access = 1'b1;
        tick();
        data_access = 1'b0;
        chk("R9 busy", 128'(busy), 128'd1);
        tick();
        serve("R9 stop", 6'd12, 32'd0, 2, 1'b1, 2'd1, mkdata(42));
        chk("R9 stop error pulse", 128'(status_set), 128'(S_NORSP | S_AUTO));
        chk("R9 resp kept", resp_words, model_resp);
        tick();
        chk("R9 idle", 128'(busy), 128'd0);

        // R9 R10 data access without zero count starts nothing
        xfer_zero = 1'b0;
        data_access = 1'b1;
        tick();
        data_access = 1'b0;
        chk("R9 no stop without zero", 128'(busy), 128'd0);

        // R10 command with auto-stop bit but count not zero: no stop
        wr(1'b0, 32'h8000_1005);
        tick();
        serve("R10 user", 6'h05, 32'hDEAD_0001, 0, 1'b0, 2'd0, mkdata(43));
        chk("R10 done only", 128'(status_set), 128'(S_DONE));
        tick();
        chk("R10 no stop", {95'd0, busy, status_set}, 128'd0);

        // R10 writes and data access while busy are ignored
        wr(1'b0, 32'h8000_1007);
        tick();
        wr(1'b1, 32'h1234_5678);
        wr(1'b0, 32'h8000_0009);
        chk("R10 regs unchanged", {64'd0, cmd_word, cmd_arg}, {64'd0, 32'h0000_1007, 32'hDEAD_0001});
        chk("R10 req fields", {90'd0, card_req_index, card_req_arg}, {90'd0, 6'h07, 32'hDEAD_0001});
        xfer_zero = 1'b1;
        data_access = 1'b1;
        tick();
        data_access = 1'b0;
        xfer_zero = 1'b0;
        serve("R10 busy", 6'h07, 32'hDEAD_0001, 0, 1'b0, 2'd0, mkdata(44));
        chk("R10 busy done", 128'(status_set), 128'(S_DONE));
        tick();
        chk("R10 access ignored", {95'd0, busy, status_set}, 128'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule